// File: doc/BRIEF.md
# Four-Entry Pairwise LRU Tracker

This block keeps the age order of four translation-buffer entries and names the oldest one for replacement. The order lives in a 6-bit vector. Each bit compares one pair of entries, and every entry touches exactly the three bits of the pairs it belongs to. When a lookup reports that an entry was used, the bits for that entry's pairs move to say that this entry is now newer than the other member of each pair. Bits for pairs that do not include the entry stay as they are.

The pair-to-bit assignment is fixed, with the lower-numbered entry first in each pair: (0,1) is bit 5, (0,2) is bit 4, (0,3) is bit 3, (1,2) is bit 2, (1,3) is bit 1 and (2,3) is bit 0. A bit value of 1 means that the lower-numbered entry of its pair is the older one. The replacement choice is decoded combinationally from the registered vector. Software can overwrite the whole vector and can read it back at any time, so that the order can be saved, restored or forced.

Top module: `lru4_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the order vector reads 6'b000000.
- R2: A use of entry 0 clears bits 5, 4 and 3 at the next clock edge and leaves bits 2, 1 and 0 unchanged.
- R3: A use of entry 1 sets bit 5, clears bits 2 and 1 at the next clock edge, and leaves bits 4, 3 and 0 unchanged.
- R4: A use of entry 2 sets bits 4 and 2, clears bit 0 at the next clock edge, and leaves bits 5, 3 and 1 unchanged.
- R5: A use of entry 3 sets bits 3, 1 and 0 at the next clock edge and leaves bits 5, 4 and 2 unchanged.
- R6: In a cycle with neither a use strobe nor a software write, the vector keeps its value.
- R7: A software write loads all six bits of the write data at the next clock edge, and the readback port always shows the current vector.
- R8: When a software write and a use strobe arrive in the same cycle, the vector takes the write data and the use has no effect.
- R9: The victim is entry 0 when bits 5, 4 and 3 are all 1. It is entry 1 when bit 5 is 0 and bits 2 and 1 are 1. It is entry 2 when bits 4 and 2 are 0 and bit 0 is 1. It is entry 3 when bits 3, 1 and 0 are all 0. In each of these cases the valid flag is 1.
- R10: When the vector matches none of the victim rules, the valid flag is 0 and the victim index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| useValid | input | 1 | An entry was used in this cycle |
| useIdx | input | 2 | Index of the entry that was used |
| swWrEn | input | 1 | Software write strobe for the order vector |
| swWrData | input | 6 | Value to load into the order vector |
| orderOut | output | 6 | Current order vector (readback) |
| victimIdx | output | 2 | Entry to replace on a miss |
| victimValid | output | 1 | The vector matched one of the victim rules |

## Verification
Any wrong bit in the order vector shows on the readback port one cycle after the update that caused it. The bench compares that port with a behavioural model on every cycle. A wrong bit can also move the victim choice or drop the valid flag in the same cycle, so the victim outputs are compared on every cycle too. Software writes force patterns that normal use cannot reach, including patterns that match no victim rule, and a use strobe is made to collide with a software write.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int ENTRIES    = 4;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int ORDER_BITS = ENTRIES * (ENTRIES - 1) / 2;

  typedef logic [ORDER_BITS-1:0] order_t;
  typedef logic [IDX_W-1:0]      idx_t;

  typedef struct packed {
    logic loadSw;
    logic applyUse;
    idx_t useIdx;
  } strobe_t;

  // Bit position of pair (lo,hi), lo < hi; the first pair takes the top bit.
  function automatic int pairPos(int lo, int hi);
    int rank = 0;
    for (int k = 0; k < lo; k++) rank += ENTRIES - 1 - k;
    rank += hi - lo - 1;
    return ORDER_BITS - 1 - rank;
  endfunction

  // Bits that become 1 when entry e is used (e is the higher member of the pair).
  function automatic order_t setMaskOf(idx_t e);
    order_t m = '0;
    for (int lo = 0; lo < ENTRIES; lo++)
      for (int hi = lo + 1; hi < ENTRIES; hi++)
        if (hi == int'(e)) m[pairPos(lo, hi)] = 1'b1;
    return m;
  endfunction

  // Bits that become 0 when entry e is used (e is the lower member of the pair).
  function automatic order_t clrMaskOf(idx_t e);
    order_t m = '0;
    for (int lo = 0; lo < ENTRIES; lo++)
      for (int hi = lo + 1; hi < ENTRIES; hi++)
        if (lo == int'(e)) m[pairPos(lo, hi)] = 1'b1;
    return m;
  endfunction

  // Entry e is the oldest when every pair names it as the older member.
  function automatic logic isOldest(order_t v, int e);
    logic ok = 1'b1;
    for (int lo = 0; lo < ENTRIES; lo++)
      for (int hi = lo + 1; hi < ENTRIES; hi++) begin
        if (lo == e && !v[pairPos(lo, hi)]) ok = 1'b0;
        if (hi == e &&  v[pairPos(lo, hi)]) ok = 1'b0;
      end
    return ok;
  endfunction
endpackage

// File: rtl/lru4_ctrl.sv
module lru4_ctrl
  import lru4_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    useValid,
  input  idx_t    useIdx,
  input  logic    swWrEn,
  output strobe_t strb
);
  always_comb begin
    strb.loadSw   = swWrEn;
    strb.applyUse = useValid && !swWrEn;
    strb.useIdx   = useIdx;
  end

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (swWrEn && useValid) |-> (strb.loadSw && !strb.applyUse)); // R8
endmodule

// File: rtl/lru4_datapath.sv
module lru4_datapath
  import lru4_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  order_t  swData,
  output order_t  orderQ,
  output idx_t    victim,
  output logic    victimOk
);
  order_t orderNext;
  logic [ENTRIES-1:0] oldest;

  always_comb begin
    orderNext = orderQ;
    if (strb.loadSw)
      orderNext = swData;
    else if (strb.applyUse)
      orderNext = (orderQ & ~clrMaskOf(strb.useIdx)) | setMaskOf(strb.useIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) orderQ <= '0;
    else       orderQ <= orderNext;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_oldest
    assign oldest[e] = isOldest(orderQ, e);
  end

  always_comb begin
    victim   = '0;
    victimOk = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (oldest[e]) begin
        victim   = idx_t'(e);
        victimOk = 1'b1;
      end
  end

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSw |=> orderQ == $past(swData)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSw && !strb.applyUse) |=> $stable(orderQ)); // R6
  AST_USE_E0: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUse && strb.useIdx == 2'd0) |=>
      (orderQ[5:3] == 3'b000 && orderQ[2:0] == $past(orderQ[2:0]))); // R2
  AST_USE_E1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUse && strb.useIdx == 2'd1) |=>
      (orderQ[5] && orderQ[2:1] == 2'b00 && orderQ[4:3] == $past(orderQ[4:3])
       && orderQ[0] == $past(orderQ[0]))); // R3
  AST_USE_E2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUse && strb.useIdx == 2'd2) |=>
      (orderQ[4] && orderQ[2] && !orderQ[0] && orderQ[5] == $past(orderQ[5])
       && orderQ[3] == $past(orderQ[3]) && orderQ[1] == $past(orderQ[1]))); // R4
  AST_USE_E3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.applyUse && strb.useIdx == 2'd3) |=>
      (orderQ[3] && orderQ[1] && orderQ[0] && orderQ[5:4] == $past(orderQ[5:4])
       && orderQ[2] == $past(orderQ[2]))); // R5
  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(oldest)); // R9
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    !victimOk |-> victim == '0); // R10
endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
  import lru4_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       useValid,
  input  logic [1:0] useIdx,
  input  logic       swWrEn,
  input  logic [5:0] swWrData,
  output logic [5:0] orderOut,
  output logic [1:0] victimIdx,
  output logic       victimValid
);
  strobe_t strb;

  lru4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .useValid(useValid), .useIdx(useIdx),
    .swWrEn(swWrEn), .strb(strb)
  );

  lru4_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .swData(swWrData),
    .orderQ(orderOut), .victim(victimIdx), .victimOk(victimValid)
  );
endmodule

// File: tb/sim_lru4_tracker.sv
module sim_lru4_tracker;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic useValid = 1'b0;
  logic [1:0] useIdx = '0;
  logic swWrEn = 1'b0;
  logic [5:0] swWrData = '0;
  logic [5:0] orderOut;
  logic [1:0] victimIdx;
  logic victimValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] refOrder = '0;
  string lastTag = "R1";

  lru4_tracker u0 (
    .clk(clk), .rstN(rstN), .useValid(useValid), .useIdx(useIdx),
    .swWrEn(swWrEn), .swWrData(swWrData), .orderOut(orderOut),
    .victimIdx(victimIdx), .victimValid(victimValid)
  );

  always #(PERIOD/2) clk = ~clk;

  // Behavioural model, written bit by bit from the requirements.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refOrder <= '0;
      lastTag  <= "R1";
    end else if (swWrEn) begin
      refOrder <= swWrData;
      lastTag  <= useValid ? "R8" : "R7";
    end else if (useValid) begin
      case (useIdx)
        2'd0: begin refOrder[5] <= 0; refOrder[4] <= 0; refOrder[3] <= 0; lastTag <= "R2"; end
        2'd1: begin refOrder[5] <= 1; refOrder[2] <= 0; refOrder[1] <= 0; lastTag <= "R3"; end
        2'd2: begin refOrder[4] <= 1; refOrder[2] <= 1; refOrder[0] <= 0; lastTag <= "R4"; end
        default: begin refOrder[3] <= 1; refOrder[1] <= 1; refOrder[0] <= 1; lastTag <= "R5"; end
      endcase
    end else begin
      lastTag <= "R6";
    end
  end

  task automatic refVictim(input logic [5:0] v, output logic [1:0] idx, output logic ok);
    ok = 1; idx = 0;
    if (v[5] && v[4] && v[3]) idx = 0;
    else if (!v[5] && v[2] && v[1]) idx = 1;
    else if (!v[4] && !v[2] && v[0]) idx = 2;
    else if (!v[3] && !v[1] && !v[0]) idx = 3;
    else ok = 0;
  endtask

  task automatic compareAll();
    logic [1:0] expIdx;
    logic expOk;
    checks++;
    if (orderOut !== refOrder) begin
      errors++;
      $display("FAIL %s order actual %b expected %b", lastTag, orderOut, refOrder);
    end
    refVictim(refOrder, expIdx, expOk);
    checks++;
    if (victimValid !== expOk || victimIdx !== expIdx) begin
      errors++;
      $display("FAIL %s victim actual %0d/%0b expected %0d/%0b",
               expOk ? "R9" : "R10", victimIdx, victimValid, expIdx, expOk);
    end
  endtask

  // Compare on every falling edge.
  always @(negedge clk) if (!done) compareAll();

  task automatic step(input logic uv, input logic [1:0] ui, input logic sw, input logic [5:0] sd);
    @(negedge clk);
    #1;
    useValid = uv; useIdx = ui; swWrEn = sw; swWrData = sd;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1: reset value while reset is held
    if (orderOut !== 6'b000000) begin
      errors++;
      $display("FAIL R1 reset actual %b expected %b", orderOut, 6'b000000);
    end
    #1 rstN = 1'b1;
    // R2..R5: each entry alone, then an ageing walk
    step(1, 3, 0, 0); step(1, 2, 0, 0); step(1, 1, 0, 0); step(1, 0, 0, 0);
    step(0, 0, 0, 0); // R6 hold
    step(1, 0, 0, 0); step(1, 1, 0, 0); step(1, 2, 0, 0); step(1, 3, 0, 0);
    step(0, 0, 0, 0);
    // R7: software loads, including R10 patterns with no valid victim
    step(0, 0, 1, 6'b101100); step(0, 0, 0, 0);
    step(0, 0, 1, 6'b010011); step(0, 0, 0, 0);
    step(0, 0, 1, 6'b111111); step(1, 1, 0, 0);
    // R8: collision of a write and a use
    step(1, 0, 1, 6'b111000); step(1, 3, 1, 6'b000111); step(0, 0, 0, 0);
    // Mixed traffic covering all 64 loadable values
    for (int k = 0; k < 64; k++) begin
      step(0, 0, 1, 6'(k));
      step(1, 2'(k % 4), 0, 0);
    end
    for (int k = 0; k < 600; k++) begin
      int r = $urandom_range(0, 9);
      step(r < 7, 2'($urandom_range(0, 3)), r >= 8, 6'($urandom_range(0, 63)));
    end
    step(0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule